// File: doc/BRIEF.md
# Accumulator CPU Primary Opcode Decoder

This block turns one primary opcode byte of an 8-bit accumulator processor with a 16-bit address space into a set of control fields. It does not fetch, execute or touch flags. A sequencer presents the byte together with a one-cycle strobe. On the next clock the decoder shows the results, and they stay put until the next strobe arrives.

The results are split into two kinds. The register, pair and condition selects are always taken from fixed bit positions of the byte. The operation class, operand source, byte length and cycle count are looked up by opcode group. Two bytes get special treatment: the prefix byte that escapes to the secondary table is flagged and not decoded, and the halt byte inside the load block is recognised as halt. The groups decoded are: 8-bit moves, immediate loads, accumulator ALU operations, 8-bit increment and decrement, 16-bit immediate loads, pair arithmetic, push and pop, high-page moves, absolute-address stores and loads, jumps, calls and conditional returns. Every other byte is reported as illegal.

Top module: `acc_opdec`

## Requirements
- R1: While reset is asserted and after it, until the first strobe, every output is zero.
- R2: A byte presented with `dec_valid` high is decoded into the outputs on the following clock edge. The outputs do not change on cycles without a strobe, whatever the opcode input does.
- R3: `dst_sel` is opcode[5:3], `src_sel` is opcode[2:0], `pair_sel` is opcode[5:4] and `cond_sel` is opcode[4:3], for every opcode.
- R4: `op_class` codes: 0 no-op, 1 8-bit load, 2 16-bit load, 3 ALU, 4 8-bit inc/dec, 5 pair arithmetic, 6 stack, 7 high page, 8 absolute address, 9 jump, 10 call, 11 return, 12 halt, 13 escape, 15 illegal. `opnd_kind` codes: 0 register or none, 1 memory at HL, 2 immediate, 3 high page. The no-op 0x00 is class 0, length 1, 4 cycles.
- R5: Register moves (0x40-0x7F), ALU register forms (0x80-0xBF) and inc/dec (00xxx10x) take 1 byte. They take 4 cycles with kind 0. When a register field they use equals 6, they take 8 cycles with kind 1. The byte 0x76 is halt (class 12, 4 cycles).
- R6: Immediate loads to a register (00xxx110) and immediate ALU forms (11xxx110) are 2 bytes, 8 cycles, kind 2. 0x36 stores an immediate to memory at HL: 2 bytes, 12 cycles, kind 1.
- R7: Forms with a 16-bit immediate are 3 bytes with kind 2. Pair load (00xx0001) takes 12 cycles. 0xEA/0xFA take 16. 0x08 (stack pointer store) takes 20. 0xC3 takes 12. 0xCD takes 24.
- R8: High-page forms are kind 3. The register-C forms 0xE2/0xF2 are 1 byte, 8 cycles. The immediate forms 0xE0/0xF0 are 2 bytes, 12 cycles.
- R9: Pair inc/dec (00xxx011) and pair add to HL (00xx1001) are class 5, 1 byte, 8 cycles. Push (11xx0101) takes 16 cycles and pop (11xx0001) takes 12. Both are class 6, 1 byte. All of these are kind 0.
- R10: `cond_used` is 1 only for conditional jumps (110xx010, 3 bytes, 12 cycles), conditional calls (110xx100, 3 bytes, 24 cycles), conditional returns (110xx000, 1 byte, 8 cycles) and conditional relative jumps (001xx000, 2 bytes, 8 cycles). The unconditional relative jump 0x18 is 2 bytes, 8 cycles, with `cond_used` 0.
- R11: 0xCB raises `escape`, class 13, length 2, 4 cycles, and `illegal` 0.
- R12: Any byte outside the groups above raises `illegal`, class 15, kind 0, length 1, 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decode strobe |
| opcode | input | 8 | Primary opcode byte |
| op_class | output | 4 | Operation class code |
| dst_sel | output | 3 | Destination register index |
| src_sel | output | 3 | Source register index |
| pair_sel | output | 2 | Register pair index |
| cond_sel | output | 2 | Condition index |
| cond_used | output | 1 | Instruction is conditional |
| opnd_kind | output | 2 | Operand source kind |
| instr_len | output | 2 | Instruction length in bytes |
| cycles | output | 5 | Clock cycle count |
| escape | output | 1 | Prefix escape byte seen |
| illegal | output | 1 | Opcode not in any group |

## Verification
Every result, both the extracted fields and the looked-up group attributes, is due exactly one clock after the edge that samples the strobe. There is no variable latency. The bench drives the opcode and strobe on a falling edge and drops the strobe on the next falling edge. It samples all outputs at that second falling edge, which is half a period after the capturing edge. For the hold check, the opcode input changes while the strobe stays low for several cycles, and the outputs are compared against the previously decoded values.

// File: rtl/acc_opdec_pkg.sv
package acc_opdec_pkg;

  localparam int OPC_W  = 8;
  localparam int REG_W  = 3;
  localparam int PAIR_W = 2;
  localparam int COND_W = 2;
  localparam int LEN_W  = 2;
  localparam int CYC_W  = 5;
  localparam int CLS_W  = 4;
  localparam int KIND_W = 2;

  localparam logic [REG_W-1:0] HL_INDEX = REG_W'(6);

  typedef enum logic [CLS_W-1:0] {
    CLS_NOP     = 4'd0,
    CLS_LD8     = 4'd1,
    CLS_LD16    = 4'd2,
    CLS_ALU     = 4'd3,
    CLS_INCDEC  = 4'd4,
    CLS_PAIR    = 4'd5,
    CLS_STACK   = 4'd6,
    CLS_HIGH    = 4'd7,
    CLS_ABS     = 4'd8,
    CLS_JUMP    = 4'd9,
    CLS_CALL    = 4'd10,
    CLS_RET     = 4'd11,
    CLS_HALT    = 4'd12,
    CLS_ESCAPE  = 4'd13,
    CLS_ILLEGAL = 4'd15
  } op_class_e;

  typedef enum logic [KIND_W-1:0] {
    KIND_REG   = 2'd0,
    KIND_HLMEM = 2'd1,
    KIND_IMM   = 2'd2,
    KIND_HIGH  = 2'd3
  } opnd_kind_e;

  typedef struct packed {
    op_class_e           cls;
    logic [REG_W-1:0]    dst;
    logic [REG_W-1:0]    src;
    logic [PAIR_W-1:0]   pair;
    logic [COND_W-1:0]   cond;
    logic                cond_used;
    opnd_kind_e          kind;
    logic [LEN_W-1:0]    len;
    logic [CYC_W-1:0]    cyc;
    logic                escape;
    logic                illegal;
  } dec_word_t;

endpackage

// File: rtl/acc_opdec_fields.sv
module acc_opdec_fields
  import acc_opdec_pkg::*;
#(
  parameter int DST_LSB  = 3,
  parameter int SRC_LSB  = 0,
  parameter int PAIR_LSB = 4,
  parameter int COND_LSB = 3
) (
  input  logic [OPC_W-1:0]  opc,
  output logic [REG_W-1:0]  dst,
  output logic [REG_W-1:0]  src,
  output logic [PAIR_W-1:0] pair,
  output logic [COND_W-1:0] cond
);

  // Fixed-position slices; positions are parameters so a variant table can move them.
  assign dst  = opc[DST_LSB  +: REG_W];
  assign src  = opc[SRC_LSB  +: REG_W];
  assign pair = opc[PAIR_LSB +: PAIR_W];
  assign cond = opc[COND_LSB +: COND_W];

endmodule

// File: rtl/acc_opdec_group.sv
module acc_opdec_group
  import acc_opdec_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  input  logic [REG_W-1:0] dst,
  input  logic [REG_W-1:0] src,
  output op_class_e        cls,
  output opnd_kind_e       kind,
  output logic [LEN_W-1:0] len,
  output logic [CYC_W-1:0] cyc,
  output logic             cond_used,
  output logic             escape,
  output logic             illegal
);

  logic src_mem;
  logic dst_mem;

  assign src_mem = (src == HL_INDEX);
  assign dst_mem = (dst == HL_INDEX);

  always_comb begin
    cls       = CLS_ILLEGAL;
    kind      = KIND_REG;
    len       = LEN_W'(1);
    cyc       = CYC_W'(4);
    cond_used = 1'b0;
    escape    = 1'b0;
    illegal   = 1'b0;
    // Exact bytes come first so that wildcard groups below cannot claim them.
    casez (opc)
      8'h00: cls = CLS_NOP;
      8'h76: cls = CLS_HALT;
      8'hCB: begin cls = CLS_ESCAPE; len = LEN_W'(2); escape = 1'b1; end
      8'h36: begin cls = CLS_LD8; kind = KIND_HLMEM; len = LEN_W'(2); cyc = CYC_W'(12); end
      8'h08: begin cls = CLS_ABS; kind = KIND_IMM; len = LEN_W'(3); cyc = CYC_W'(20); end
      8'hEA, 8'hFA: begin cls = CLS_ABS; kind = KIND_IMM; len = LEN_W'(3); cyc = CYC_W'(16); end
      8'hE2, 8'hF2: begin cls = CLS_HIGH; kind = KIND_HIGH; cyc = CYC_W'(8); end
      8'hE0, 8'hF0: begin cls = CLS_HIGH; kind = KIND_HIGH; len = LEN_W'(2); cyc = CYC_W'(12); end
      8'hC3: begin cls = CLS_JUMP; kind = KIND_IMM; len = LEN_W'(3); cyc = CYC_W'(12); end
      8'hCD: begin cls = CLS_CALL; kind = KIND_IMM; len = LEN_W'(3); cyc = CYC_W'(24); end
      8'h18: begin cls = CLS_JUMP; kind = KIND_IMM; len = LEN_W'(2); cyc = CYC_W'(8); end
      8'b001??000: begin
        cls = CLS_JUMP; kind = KIND_IMM; len = LEN_W'(2); cyc = CYC_W'(8); cond_used = 1'b1;
      end
      8'b110??010: begin
        cls = CLS_JUMP; kind = KIND_IMM; len = LEN_W'(3); cyc = CYC_W'(12); cond_used = 1'b1;
      end
      8'b110??100: begin
        cls = CLS_CALL; kind = KIND_IMM; len = LEN_W'(3); cyc = CYC_W'(24); cond_used = 1'b1;
      end
      8'b110??000: begin cls = CLS_RET; cyc = CYC_W'(8); cond_used = 1'b1; end
      8'b01??????: begin
        cls = CLS_LD8;
        if (src_mem || dst_mem) begin kind = KIND_HLMEM; cyc = CYC_W'(8); end
      end
      8'b10??????: begin
        cls = CLS_ALU;
        if (src_mem) begin kind = KIND_HLMEM; cyc = CYC_W'(8); end
      end
      8'b11???110: begin cls = CLS_ALU; kind = KIND_IMM; len = LEN_W'(2); cyc = CYC_W'(8); end
      8'b00???110: begin cls = CLS_LD8; kind = KIND_IMM; len = LEN_W'(2); cyc = CYC_W'(8); end
      8'b00???10?: begin
        cls = CLS_INCDEC;
        if (dst_mem) begin kind = KIND_HLMEM; cyc = CYC_W'(8); end
      end
      8'b00??0001: begin cls = CLS_LD16; kind = KIND_IMM; len = LEN_W'(3); cyc = CYC_W'(12); end
      8'b00???011, 8'b00??1001: begin cls = CLS_PAIR; cyc = CYC_W'(8); end
      8'b11??0101: begin cls = CLS_STACK; cyc = CYC_W'(16); end
      8'b11??0001: begin cls = CLS_STACK; cyc = CYC_W'(12); end
      default: illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/acc_opdec_hold.sv
module acc_opdec_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load_en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/acc_opdec.sv
module acc_opdec
  import acc_opdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid,
  input  logic [OPC_W-1:0]  opcode,
  output logic [CLS_W-1:0]  op_class,
  output logic [REG_W-1:0]  dst_sel,
  output logic [REG_W-1:0]  src_sel,
  output logic [PAIR_W-1:0] pair_sel,
  output logic [COND_W-1:0] cond_sel,
  output logic              cond_used,
  output logic [KIND_W-1:0] opnd_kind,
  output logic [LEN_W-1:0]  instr_len,
  output logic [CYC_W-1:0]  cycles,
  output logic              escape,
  output logic              illegal
);

  localparam int WORD_W = $bits(dec_word_t);

  // Reset asserts asynchronously and is released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  dec_word_t  word_d;
  dec_word_t  word_q;
  op_class_e  g_cls;
  opnd_kind_e g_kind;

  acc_opdec_fields u_fields (
    .opc  (opcode),
    .dst  (word_d.dst),
    .src  (word_d.src),
    .pair (word_d.pair),
    .cond (word_d.cond)
  );

  acc_opdec_group u_group (
    .opc       (opcode),
    .dst       (word_d.dst),
    .src       (word_d.src),
    .cls       (g_cls),
    .kind      (g_kind),
    .len       (word_d.len),
    .cyc       (word_d.cyc),
    .cond_used (word_d.cond_used),
    .escape    (word_d.escape),
    .illegal   (word_d.illegal)
  );

  assign word_d.cls  = g_cls;
  assign word_d.kind = g_kind;

  acc_opdec_hold #(.W(WORD_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_sn),
    .load_en (dec_valid),
    .d       (word_d),
    .q       (word_q)
  );

  assign op_class  = word_q.cls;
  assign dst_sel   = word_q.dst;
  assign src_sel   = word_q.src;
  assign pair_sel  = word_q.pair;
  assign cond_sel  = word_q.cond;
  assign cond_used = word_q.cond_used;
  assign opnd_kind = word_q.kind;
  assign instr_len = word_q.len;
  assign cycles    = word_q.cyc;
  assign escape    = word_q.escape;
  assign illegal   = word_q.illegal;

endmodule

// File: rtl/acc_opdec_chk.sv
module acc_opdec_chk
  import acc_opdec_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              dec_valid,
  input logic [OPC_W-1:0]  opcode,
  input logic [CLS_W-1:0]  op_class,
  input logic [REG_W-1:0]  dst_sel,
  input logic [REG_W-1:0]  src_sel,
  input logic [PAIR_W-1:0] pair_sel,
  input logic [COND_W-1:0] cond_sel,
  input logic              cond_used,
  input logic [LEN_W-1:0]  instr_len,
  input logic [CYC_W-1:0]  cycles,
  input logic              escape,
  input logic              illegal
);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |=> $stable(op_class) && $stable(dst_sel) && $stable(instr_len)
                   && $stable(cycles) && $stable(illegal) && $stable(escape));

  a_r3_fields: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> dst_sel == $past(opcode[5:3]) && src_sel == $past(opcode[2:0])
                  && pair_sel == $past(opcode[5:4]) && cond_sel == $past(opcode[4:3]));

  a_r11_escape: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && opcode == 8'hCB) |=> escape && !illegal && op_class == 4'd13);

  a_r12_illegal_shape: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> instr_len == 2'd1 && cycles == 5'd4 && op_class == 4'd15);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({illegal, escape, cond_used}));

  a_r7_long_form: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && (opcode == 8'hCD || opcode == 8'hC3 || opcode == 8'h08)) |=> instr_len == 2'd3);

endmodule

bind acc_opdec acc_opdec_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sn),
  .dec_valid (dec_valid),
  .opcode    (opcode),
  .op_class  (op_class),
  .dst_sel   (dst_sel),
  .src_sel   (src_sel),
  .pair_sel  (pair_sel),
  .cond_sel  (cond_sel),
  .cond_used (cond_used),
  .instr_len (instr_len),
  .cycles    (cycles),
  .escape    (escape),
  .illegal   (illegal)
);

// File: tb/acc_opdec_tb.sv
module acc_opdec_tb;

  logic       clk;
  logic       rst_n;
  logic       dec_valid;
  logic [7:0] opcode;
  logic [3:0] op_class;
  logic [2:0] dst_sel;
  logic [2:0] src_sel;
  logic [1:0] pair_sel;
  logic [1:0] cond_sel;
  logic       cond_used;
  logic [1:0] opnd_kind;
  logic [1:0] instr_len;
  logic [4:0] cycles;
  logic       escape;
  logic       illegal;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  acc_opdec u_dut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .opcode(opcode),
    .op_class(op_class), .dst_sel(dst_sel), .src_sel(src_sel),
    .pair_sel(pair_sel), .cond_sel(cond_sel), .cond_used(cond_used),
    .opnd_kind(opnd_kind), .instr_len(instr_len), .cycles(cycles),
    .escape(escape), .illegal(illegal)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {opcode, class, kind, len, cycles, cond_used, escape, illegal}
  localparam int N = 34;
  localparam logic [23:0] VEC [N] = '{
    {8'h00, 4'd0,  2'd0, 2'd1, 5'd4,  3'b000},
    {8'h41, 4'd1,  2'd0, 2'd1, 5'd4,  3'b000},
    {8'h46, 4'd1,  2'd1, 2'd1, 5'd8,  3'b000},
    {8'h70, 4'd1,  2'd1, 2'd1, 5'd8,  3'b000},
    {8'h76, 4'd12, 2'd0, 2'd1, 5'd4,  3'b000},
    {8'h06, 4'd1,  2'd2, 2'd2, 5'd8,  3'b000},
    {8'h3E, 4'd1,  2'd2, 2'd2, 5'd8,  3'b000},
    {8'h36, 4'd1,  2'd1, 2'd2, 5'd12, 3'b000},
    {8'h80, 4'd3,  2'd0, 2'd1, 5'd4,  3'b000},
    {8'hBE, 4'd3,  2'd1, 2'd1, 5'd8,  3'b000},
    {8'hFE, 4'd3,  2'd2, 2'd2, 5'd8,  3'b000},
    {8'h3C, 4'd4,  2'd0, 2'd1, 5'd4,  3'b000},
    {8'h35, 4'd4,  2'd1, 2'd1, 5'd8,  3'b000},
    {8'h21, 4'd2,  2'd2, 2'd3, 5'd12, 3'b000},
    {8'h0B, 4'd5,  2'd0, 2'd1, 5'd8,  3'b000},
    {8'h39, 4'd5,  2'd0, 2'd1, 5'd8,  3'b000},
    {8'hC5, 4'd6,  2'd0, 2'd1, 5'd16, 3'b000},
    {8'hF1, 4'd6,  2'd0, 2'd1, 5'd12, 3'b000},
    {8'hE2, 4'd7,  2'd3, 2'd1, 5'd8,  3'b000},
    {8'hF0, 4'd7,  2'd3, 2'd2, 5'd12, 3'b000},
    {8'hEA, 4'd8,  2'd2, 2'd3, 5'd16, 3'b000},
    {8'h08, 4'd8,  2'd2, 2'd3, 5'd20, 3'b000},
    {8'hC3, 4'd9,  2'd2, 2'd3, 5'd12, 3'b000},
    {8'hDA, 4'd9,  2'd2, 2'd3, 5'd12, 3'b100},
    {8'h18, 4'd9,  2'd2, 2'd2, 5'd8,  3'b000},
    {8'h28, 4'd9,  2'd2, 2'd2, 5'd8,  3'b100},
    {8'hCD, 4'd10, 2'd2, 2'd3, 5'd24, 3'b000},
    {8'hC4, 4'd10, 2'd2, 2'd3, 5'd24, 3'b100},
    {8'hD8, 4'd11, 2'd0, 2'd1, 5'd8,  3'b100},
    {8'hCB, 4'd13, 2'd0, 2'd2, 5'd4,  3'b010},
    {8'h10, 4'd15, 2'd0, 2'd1, 5'd4,  3'b001},
    {8'hD3, 4'd15, 2'd0, 2'd1, 5'd4,  3'b001},
    {8'hFB, 4'd15, 2'd0, 2'd1, 5'd4,  3'b001},
    {8'h27, 4'd15, 2'd0, 2'd1, 5'd4,  3'b001}
  };
  localparam string TAG [N] = '{
    "R4", "R5", "R5", "R5", "R5", "R6", "R6", "R6", "R5", "R5", "R6", "R5",
    "R5", "R7", "R9", "R9", "R9", "R9", "R8", "R8", "R7", "R7", "R7", "R10",
    "R10", "R10", "R7", "R10", "R10", "R11", "R12", "R12", "R12", "R12"
  };

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Strobe on a falling edge; results are due after the next rising edge.
  task automatic decode(input logic [7:0] op);
    @(negedge clk);
    opcode    = op;
    dec_valid = 1'b1;
    @(negedge clk);
    dec_valid = 1'b0;
  endtask

  function automatic logic [31:0] outs_packed();
    return {op_class, opnd_kind, instr_len, cycles, cond_used, escape, illegal,
            dst_sel, src_sel, pair_sel, cond_sel};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] snap;
    rst_n     = 1'b0;
    dec_valid = 1'b0;
    opcode    = 8'hCD;
    repeat (3) @(negedge clk);
    // R1: outputs zero during reset
    check("R1", "reset outputs", outs_packed(), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "outputs after release, no strobe", outs_packed(), 32'd0);

    for (int i = 0; i < N; i++) begin
      logic [7:0] op;
      op = VEC[i][23:16];
      decode(op);
      check(TAG[i], $sformatf("class op=%02h", op), 32'(op_class), 32'(VEC[i][15:12]));
      check(TAG[i], $sformatf("kind op=%02h", op), 32'(opnd_kind), 32'(VEC[i][11:10]));
      check(TAG[i], $sformatf("len op=%02h", op), 32'(instr_len), 32'(VEC[i][9:8]));
      check(TAG[i], $sformatf("cycles op=%02h", op), 32'(cycles), 32'(VEC[i][7:3]));
      check(TAG[i], $sformatf("cond/esc/ill op=%02h", op),
            32'({cond_used, escape, illegal}), 32'(VEC[i][2:0]));
    end

    // R3: fixed field positions over every byte
    for (int v = 0; v < 256; v++) begin
      logic [7:0] op;
      op = 8'(v);
      decode(op);
      check("R3", $sformatf("fields op=%02h", op), 32'({dst_sel, src_sel, pair_sel, cond_sel}),
            32'({op[5:3], op[2:0], op[5:4], op[4:3]}));
    end

    // R2: outputs hold while the opcode input moves without a strobe
    decode(8'hCD);
    snap = outs_packed();
    opcode = 8'h10;
    @(negedge clk);
    opcode = 8'h46;
    @(negedge clk);
    opcode = 8'hCB;
    @(negedge clk);
    check("R2", "hold without strobe", outs_packed(), snap);
    // R2: next strobe takes effect one cycle later
    @(negedge clk);
    opcode    = 8'h76;
    dec_valid = 1'b1;
    @(posedge clk);
    #1;
    check("R2", "class one edge after strobe", 32'(op_class), 32'd12);
    @(negedge clk);
    dec_valid = 1'b0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule